// File: doc/BRIEF.md
# Two-Line Clocked Scan Storage Chain

This block is a chain of level-sensitive storage cells built for scan testing. Each cell holds a master latch and a slave latch. The master latch has two write ports. The normal port takes functional data and the scan port takes the output of the previous cell in the chain. The slave latch copies the master latch and drives the cell output.

Three internal clocks control each cell: a normal capture clock, a scan capture clock and a slave clock. These three clocks are not routed separately. A small decoder in every cell builds them from two shared lines. The encoding works because the cell never needs more than one of its clocks at a time. With both lines low, no clock is active. With only the first line high, the normal capture clock is active. With only the second line high, the slave clock is active. With both lines high, the scan capture clock is active.

In functional operation the two lines carry the usual pair of non-overlapping system clocks. For scan, the second line is held high and the first line toggles, so scan capture and slave transfer take turns and the chain shifts by one cell per toggle. No scan-enable wire reaches the cells.

Top module: `scff_chain`

## Requirements
- R1: An active-low reset clears every master and slave latch to 0 at once, without waiting for any clock line. While reset is held, no line pattern changes any output.
- R2: With both lines low ({m_line,s_line}=00), every output holds, even when norm_d or scan_in change.
- R3: With {m_line,s_line}=10, each master latch follows its norm_d bit. q does not change.
- R4: With {m_line,s_line}=01, each slave latch copies its master latch, and q shows the result.
- R5: With {m_line,s_line}=11, each master latch loads its scan source: scan_in for cell 0 and q[i-1] for cell i. q does not change.
- R6: At most one of a cell's three decoded clocks is high at any time.
- R7: A normal two-phase sequence (10, then 00, then 01) puts on q the norm_d value present during the 10 phase.
- R8: With s_line held high and m_line toggling, each 11→01 pair moves the chain by one cell toward q[N-1]. scan_out always equals q[N-1].
- R9: The master latch is transparent. When several 10 steps in a row carry different norm_d values, the value in the last step is the one kept.
- R10: The port that is not selected has no effect. scan_in has no effect during 10, and norm_d has no effect during 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all latches |
| m_line | input | 1 | First shared control line |
| s_line | input | 1 | Second shared control line |
| norm_d | input | CHAIN_LEN | Functional data, one bit per cell |
| scan_in | input | 1 | Serial scan input to cell 0 |
| q | output | CHAIN_LEN | Slave latch outputs |
| scan_out | output | 1 | Serial scan output, the last cell's slave |

## Verification
Normal-mode stimulus alternates between patterns such as A5 and 3C on norm_d while scan_in is driven to the opposite value. A correct q therefore shows that the data came from the normal port and not from the scan port. Runs of back-to-back normal captures with changing data show that the last value is kept, which checks that the master latch is transparent. Scan shifting uses a 0011 walking pattern followed by all-ones and all-zeros fills, each pushed through the whole chain. These patterns expose stuck, swapped or skipped cells, and they also show whether norm_d leaks in during scan capture. An asynchronous reset issued in the middle of a run must clear the outputs before the next clock line moves.

// File: rtl/scff_pkg.sv
`timescale 1ns/1ps
package scff_pkg;
  // Line pair encoding {m,s}
  typedef enum logic [1:0] {
    SEL_IDLE  = 2'b00,
    SEL_SLAVE = 2'b01,
    SEL_NORM  = 2'b10,
    SEL_SCAN  = 2'b11
  } line_sel_e;

  typedef struct packed {
    logic norm_ck;
    logic scan_ck;
    logic slave_ck;
  } cell_clk_t;

  function automatic cell_clk_t decode_lines(input logic m, input logic s);
    cell_clk_t c;
    c.norm_ck  = m & ~s;
    c.scan_ck  = m & s;
    c.slave_ck = ~m & s;
    return c;
  endfunction
endpackage

// File: rtl/scff_decode.sv
`timescale 1ns/1ps
module scff_decode
  import scff_pkg::*;
(
  input  logic m,
  input  logic s,
  output logic norm_ck,
  output logic scan_ck,
  output logic slave_ck
);
  cell_clk_t clk_set;
  assign clk_set  = decode_lines(m, s);
  assign norm_ck  = clk_set.norm_ck;
  assign scan_ck  = clk_set.scan_ck;
  assign slave_ck = clk_set.slave_ck;
endmodule

// File: rtl/scff_cell.sv
`timescale 1ns/1ps
module scff_cell (
  input  logic rst_n,
  input  logic m,
  input  logic s,
  input  logic nd,
  input  logic sd,
  output logic q,
  output logic mst,
  output logic nck,
  output logic sck,
  output logic slv
);
  logic mst_en;
  logic mst_d;

  scff_decode u_dec (
    .m        (m),
    .s        (s),
    .norm_ck  (nck),
    .scan_ck  (sck),
    .slave_ck (slv)
  );

  assign mst_en = nck | sck;
  assign mst_d  = sck ? sd : nd;

  // Master latch: two write ports, selected by the decoded clock
  always_latch begin
    if (!rst_n)      mst <= 1'b0;
    else if (mst_en) mst <= mst_d;
  end

  // Slave latch
  always_latch begin
    if (!rst_n)   q <= 1'b0;
    else if (slv) q <= mst;
  end
endmodule

// File: rtl/scff_chain.sv
`timescale 1ns/1ps
module scff_chain #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 rst_n,
  input  logic                 m_line,
  input  logic                 s_line,
  input  logic [CHAIN_LEN-1:0] norm_d,
  input  logic                 scan_in,
  output logic [CHAIN_LEN-1:0] q,
  output logic                 scan_out
);
  localparam int LAST = CHAIN_LEN - 1;

  // Named internal events for the checker
  logic [CHAIN_LEN-1:0] mst_v;
  logic [CHAIN_LEN-1:0] nck_v;
  logic [CHAIN_LEN-1:0] sck_v;
  logic [CHAIN_LEN-1:0] slv_v;
  logic [CHAIN_LEN-1:0] scan_src;

  assign scan_src = {q[LAST-1:0], scan_in};

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    scff_cell u_cell (
      .rst_n (rst_n),
      .m     (m_line),
      .s     (s_line),
      .nd    (norm_d[i]),
      .sd    (scan_src[i]),
      .q     (q[i]),
      .mst   (mst_v[i]),
      .nck   (nck_v[i]),
      .sck   (sck_v[i]),
      .slv   (slv_v[i])
    );
  end

  assign scan_out = q[LAST];
endmodule

// File: rtl/scff_chain_chk.sv
`timescale 1ns/1ps
module scff_chain_chk #(
  parameter int CHAIN_LEN = 8
) (
  input logic                 rst_n,
  input logic [CHAIN_LEN-1:0] norm_d,
  input logic                 scan_in,
  input logic [CHAIN_LEN-1:0] q,
  input logic [CHAIN_LEN-1:0] mst_v,
  input logic [CHAIN_LEN-1:0] nck_v,
  input logic [CHAIN_LEN-1:0] sck_v,
  input logic [CHAIN_LEN-1:0] slv_v
);
  // Outputs seen just before reset is released must be cleared
  assert_reset_clear_R1: assert property (@(posedge rst_n) q == '0);

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_chk
    always_comb begin
      if (rst_n) begin
        assert_one_clock_R6: assert ($onehot0({nck_v[i], sck_v[i], slv_v[i]}));
      end
    end

    assert_norm_capture_R3: assert property (
      @(negedge nck_v[i]) disable iff (!rst_n) mst_v[i] == norm_d[i]);

    assert_slave_copy_R4: assert property (
      @(negedge slv_v[i]) disable iff (!rst_n) q[i] == mst_v[i]);

    if (i == 0) begin : g_first
      assert_scan_capture_R5: assert property (
        @(negedge sck_v[i]) disable iff (!rst_n) mst_v[i] == scan_in);
    end else begin : g_rest
      assert_scan_capture_R5: assert property (
        @(negedge sck_v[i]) disable iff (!rst_n) mst_v[i] == q[i-1]);
    end
  end
endmodule

bind scff_chain scff_chain_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .rst_n   (rst_n),
  .norm_d  (norm_d),
  .scan_in (scan_in),
  .q       (q),
  .mst_v   (mst_v),
  .nck_v   (nck_v),
  .sck_v   (sck_v),
  .slv_v   (slv_v)
);

// File: tb/sim_scff_chain.sv
`timescale 1ns/1ps
module sim_scff_chain;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   ms;
  logic [N-1:0] nd;
  logic         si;
  logic [N-1:0] q;
  logic         so;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic [N-1:0] ref_m;
  logic [N-1:0] ref_s;

  always #2 clk = ~clk;

  scff_chain #(.CHAIN_LEN(N)) u0 (
    .rst_n    (rst_n),
    .m_line   (ms[1]),
    .s_line   (ms[0]),
    .norm_d   (nd),
    .scan_in  (si),
    .q        (q),
    .scan_out (so)
  );

  task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock per step: drive after posedge, compare at negedge
  task automatic step(input logic [1:0] sel, input logic [N-1:0] d,
                      input logic s_in, input string tag);
    @(posedge clk);
    #1;
    ms = sel; nd = d; si = s_in;
    if (rst_n) begin
      case (sel)
        2'b10: ref_m = d;
        2'b11: ref_m = {ref_s[N-2:0], s_in};
        2'b01: ref_s = ref_m;
        default: ;
      endcase
    end
    @(negedge clk);
    check(tag, {so, q}, {ref_s[N-1], ref_s});
  endtask

  // Normal capture then transfer
  task automatic normal_cycle(input logic [N-1:0] d, input logic noise);
    step(2'b10, d, noise, "R3");
    step(2'b00, ~d, ~noise, "R2");
    step(2'b01, ~d, noise, "R7");
    step(2'b00, d, noise, "R2");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ms = 2'b00; nd = '0; si = 1'b0;
    ref_m = '0; ref_s = '0;
    step(2'b00, 8'hFF, 1'b1, "R1");
    step(2'b10, 8'hFF, 1'b1, "R1");
    step(2'b00, 8'hFF, 1'b1, "R1");
    step(2'b01, 8'hFF, 1'b1, "R1");
    step(2'b00, 8'h00, 1'b0, "R1");
    rst_n = 1'b1;

    // Normal mode, scan_in opposite to data (R10)
    normal_cycle(8'hA5, 1'b1);
    normal_cycle(8'h3C, 1'b0);
    normal_cycle(8'hFF, 1'b0);
    normal_cycle(8'h00, 1'b1);

    // Transparency: last value of a 10 run kept (R9)
    step(2'b10, 8'h3C, 1'b1, "R9");
    step(2'b10, 8'h96, 1'b0, "R9");
    step(2'b10, 8'hC3, 1'b1, "R9");
    step(2'b00, 8'hFF, 1'b1, "R2");
    step(2'b01, 8'hFF, 1'b1, "R9");
    step(2'b00, 8'h00, 1'b0, "R2");

    // Scan shift, walking 0011 pattern; norm_d noise ignored (R10)
    step(2'b01, 8'h5A, 1'b0, "R8");
    for (int k = 0; k < 2 * N; k++) begin
      logic b;
      b = (k % 4) >= 2;
      step(2'b11, (k % 2) ? 8'hFF : 8'h00, b, "R5");
      step(2'b01, 8'hA5, ~b, "R8");
    end
    // All-ones fill then all-zeros fill
    for (int k = 0; k < N + 1; k++) begin
      step(2'b11, 8'h00, 1'b1, "R10");
      step(2'b01, 8'h00, 1'b0, "R8");
    end
    for (int k = 0; k < N + 1; k++) begin
      step(2'b11, 8'hFF, 1'b0, "R10");
      step(2'b01, 8'hFF, 1'b1, "R8");
    end
    step(2'b00, 8'h00, 1'b0, "R2");

    // Load something, then asynchronous reset mid-cycle
    normal_cycle(8'h6E, 1'b1);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R1", {so, q}, '0);
    ref_m = '0; ref_s = '0;
    step(2'b10, 8'hFF, 1'b1, "R1");
    step(2'b00, 8'hFF, 1'b1, "R1");
    step(2'b01, 8'hFF, 1'b1, "R1");
    step(2'b00, 8'h00, 1'b0, "R1");
    rst_n = 1'b1;
    normal_cycle(8'h81, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule